// File: doc/BRIEF.md
# Address Phase Responder with Byte-Lane Decode

This block answers the address phase of a split-transaction bus on the memory side. When the transfer-start strobe is seen, it captures the address offset, the burst flag and the 3-bit size code. After a programmable number of wait states it raises the address acknowledge, which ends the address tenure.

From the captured attributes it works out which of the eight byte lanes of the 64-bit data bus will carry valid data, and how many data beats the following data tenure needs. It flags any single-beat request whose size code is unknown or whose bytes would run past the end of the doubleword. A second strobe that arrives while a tenure is still waiting is dropped and reported as a protocol error.

The data-phase handshake, arbitration and snoop response are handled elsewhere.

Top module: `addr_tenure_slave`

## Requirements
- R1: A strobe accepted at a clock edge never produces `ack_o` in the cycle of that strobe. With `wait_i` = 0, `ack_o` is high in the cycle right after that edge.
- R2: `wait_i` is sampled together with the accepted strobe. Each unit of it delays `ack_o` by one further cycle: with value w, `ack_o` is high in cycle w counted from 0 after the capture edge.
- R3: `ack_o` is high for exactly one cycle per tenure. It then drops, unless a new strobe is accepted at that same edge.
- R4: Single beats (`burst_i` = 0) use these byte counts: size 3'b001 = 1, 3'b010 = 2, 3'b011 = 3, 3'b100 = 4, 3'b000 = 8. `lane_en_o` is a contiguous mask of that many ones shifted left by `addr_i[2:0]`, with bit i standing for byte offset i. `beats_o` = 1 and `err_o` = 0.
- R5: With `burst_i` = 1, `lane_en_o` = 8'hFF, `beats_o` = 4 and `err_o` = 0, whatever the size code and address offset.
- R6: A single beat with size code 3'b101..3'b111, or with offset plus byte count above 8, gives `err_o` = 1, `lane_en_o` = 0 and `beats_o` = 0.
- R7: A strobe at an edge where a tenure is active and not in its acknowledge cycle is ignored. It changes neither the decode outputs nor the acknowledge timing, and `proto_err_o` is high for the one following cycle. A strobe in the acknowledge cycle starts a new tenure.
- R8: While `rst_ni` is low and after its release, all outputs are 0 until the first accepted strobe.
- R9: `lane_en_o`, `beats_o` and `err_o` take new values one cycle after an accepted strobe and hold them until the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer-start strobe |
| addr_i | input | 32 | Transfer address; bits [2:0] give the byte offset |
| burst_i | input | 1 | Burst request |
| size_i | input | 3 | Transfer size code |
| wait_i | input | 3 | Wait states before acknowledge |
| ack_o | output | 1 | Address acknowledge |
| lane_en_o | output | 8 | Byte-lane enables, bit i = byte offset i |
| beats_o | output | 3 | Data beats for the data tenure |
| err_o | output | 1 | Illegal size/alignment |
| proto_err_o | output | 1 | Strobe dropped during a tenure |

## Verification
The decode outputs and `proto_err_o` are registered, so they are due in the cycle after the capture edge. `ack_o` is due exactly w cycles later, for a sampled wait count of w. The bench drives inputs on falling edges and samples on falling edges. It counts cycles from 0 after the capture edge and checks `ack_o` in every cycle of the tenure, so that an early, late or doubled acknowledge is seen. It checks decode results in cycle 0 and the protocol flag in the cycle after the injected strobe. It then rechecks the decode outputs there to show that the dropped strobe changed nothing.

// File: rtl/atsl_pkg.sv
package atsl_pkg;
  localparam int unsigned LANES       = 8;
  localparam int unsigned OFF_W       = $clog2(LANES);
  localparam int unsigned LEN_W       = OFF_W + 1;
  localparam int unsigned SIZE_W      = 3;
  localparam int unsigned BURST_BEATS = 4;
  localparam int unsigned BEAT_W      = $clog2(BURST_BEATS + 1);

  typedef enum logic [SIZE_W-1:0] {
    SZ_DWORD = 3'b000,
    SZ_BYTE1 = 3'b001,
    SZ_BYTE2 = 3'b010,
    SZ_BYTE3 = 3'b011,
    SZ_BYTE4 = 3'b100
  } size_code_e;

  // byte count of a single beat, 0 for an unknown code
  function automatic logic [LEN_W-1:0] size_len(input logic [SIZE_W-1:0] code);
    case (code)
      SZ_DWORD: size_len = LEN_W'(LANES);
      SZ_BYTE1: size_len = LEN_W'(1);
      SZ_BYTE2: size_len = LEN_W'(2);
      SZ_BYTE3: size_len = LEN_W'(3);
      SZ_BYTE4: size_len = LEN_W'(4);
      default:  size_len = '0;
    endcase
  endfunction
endpackage

// File: rtl/atsl_lane_dec.sv
module atsl_lane_dec
  import atsl_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic              burst_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [LANES-1:0]  lane_en_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic              err_o
);
  logic [LEN_W-1:0] len;
  logic [LEN_W:0]   end_pos;
  logic             bad;
  logic [LANES-1:0] mask;

  assign len     = size_len(size_i);
  assign end_pos = {1'b0, len} + (LEN_W+1)'(off_i);
  assign bad     = (len == '0) || (end_pos > (LEN_W+1)'(LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = ((LEN_W+1)'(i) >= (LEN_W+1)'(off_i)) &&
                     ((LEN_W+1)'(i) <  end_pos);
  end

  always_comb begin
    if (burst_i) begin
      lane_en_o = '1;
      beats_o   = BEAT_W'(BURST_BEATS);
      err_o     = 1'b0;
    end else if (bad) begin
      lane_en_o = '0;
      beats_o   = '0;
      err_o     = 1'b1;
    end else begin
      lane_en_o = mask;
      beats_o   = BEAT_W'(1);
      err_o     = 1'b0;
    end
  end
endmodule

// File: rtl/atsl_ack_timer.sv
module atsl_ack_timer #(
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              accept_o,
  output logic              ack_o,
  output logic              proto_err_o
);
  logic              busy_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              ack_cyc;

  assign ack_cyc  = busy_q && (cnt_q == '0);
  assign accept_o = start_i && (!busy_q || ack_cyc);
  assign ack_o    = ack_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      proto_err_o <= 1'b0;
    end else begin
      proto_err_o <= start_i && busy_q && !ack_cyc;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= wait_i;
      end else if (busy_q) begin
        if (ack_cyc) busy_q <= 1'b0;
        else         cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_tenure_slave.sv
module addr_tenure_slave
  import atsl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              burst_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              ack_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic              err_o,
  output logic              proto_err_o
);
  logic              accept;
  logic [LANES-1:0]  dec_lanes;
  logic [BEAT_W-1:0] dec_beats;
  logic              dec_err;

  atsl_ack_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .wait_i      (wait_i),
    .accept_o    (accept),
    .ack_o       (ack_o),
    .proto_err_o (proto_err_o)
  );

  atsl_lane_dec u_dec (
    .off_i     (addr_i[OFF_W-1:0]),
    .burst_i   (burst_i),
    .size_i    (size_i),
    .lane_en_o (dec_lanes),
    .beats_o   (dec_beats),
    .err_o     (dec_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_en_o <= '0;
      beats_o   <= '0;
      err_o     <= 1'b0;
    end else if (accept) begin
      lane_en_o <= dec_lanes;
      beats_o   <= dec_beats;
      err_o     <= dec_err;
    end
  end
endmodule

// File: rtl/addr_tenure_slave_chk.sv
module addr_tenure_slave_chk
  import atsl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              accept,
  input logic              ack_o,
  input logic [LANES-1:0]  lane_en_o,
  input logic [BEAT_W-1:0] beats_o,
  input logic              err_o,
  input logic              proto_err_o
);
  assert_ack_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && !start_i |=> !ack_o);

  assert_no_same_cycle_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o && accept |=> ack_o || !accept);

  assert_err_no_lanes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (lane_en_o == '0) && (beats_o == '0));

  assert_burst_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beats_o == BEAT_W'(BURST_BEATS)) |-> (lane_en_o == '1) && !err_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(lane_en_o) && $stable(beats_o) && $stable(err_o));

  assert_proto_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $past(start_i) && !$past(accept));
endmodule

bind addr_tenure_slave addr_tenure_slave_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .accept      (accept),
  .ack_o       (ack_o),
  .lane_en_o   (lane_en_o),
  .beats_o     (beats_o),
  .err_o       (err_o),
  .proto_err_o (proto_err_o)
);

// File: tb/addr_tenure_slave_bench.sv
module addr_tenure_slave_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic       burst_i = 1'b0;
  logic [2:0] size_i = '0;
  logic [2:0] wait_i = '0;
  logic       ack_o;
  logic [7:0] lane_en_o;
  logic [2:0] beats_o;
  logic       err_o;
  logic       proto_err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  addr_tenure_slave u_addr_tenure_slave (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .burst_i(burst_i), .size_i(size_i), .wait_i(wait_i), .ack_o(ack_o),
    .lane_en_o(lane_en_o), .beats_o(beats_o), .err_o(err_o),
    .proto_err_o(proto_err_o)
  );

  function automatic int blen(input logic [2:0] s);
    case (s)
      3'b000: return 8;
      3'b001: return 1;
      3'b010: return 2;
      3'b011: return 3;
      3'b100: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [12:0] expect_dec(input logic b, input logic [2:0] s,
                                             input logic [2:0] off);
    int n;
    logic [7:0] m;
    if (b) return {8'hFF, 3'd4, 1'b0, 1'b0};
    n = blen(s);
    if (n == 0 || int'(off) + n > 8) return {8'h00, 3'd0, 1'b1, 1'b0};
    m = 8'((16'(1) << n) - 1) << off;
    return {m, 3'd1, 1'b0, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts at a falling edge, returns at the falling edge of the ack cycle
  task automatic txn(input logic [31:0] a, input logic b, input logic [2:0] s,
                     input logic [2:0] w, input bit inject);
    logic [12:0] e;
    bit ack_ok;
    e = expect_dec(b, s, a[2:0]);
    start_i = 1'b1; addr_i = a; burst_i = b; size_i = s; wait_i = w;
    @(negedge clk_i);
    start_i = 1'b0;
    if (b) chk(lane_en_o == 8'hFF && beats_o == 3'd4 && !err_o, "R5",
               {lane_en_o, beats_o, err_o}, {e[12:5], e[4:2], e[1]});
    else if (e[1]) chk(lane_en_o == e[12:5] && beats_o == e[4:2] && err_o, "R6",
               {lane_en_o, beats_o, err_o}, {e[12:5], e[4:2], e[1]});
    else chk(lane_en_o == e[12:5] && beats_o == e[4:2] && !err_o, "R4 R9",
               {lane_en_o, beats_o, err_o}, {e[12:5], e[4:2], e[1]});
    ack_ok = 1;
    for (int k = 0; k <= int'(w); k++) begin
      if (ack_o != (k == int'(w))) ack_ok = 0;
      if (inject && k == 2) begin
        chk(proto_err_o == 1'b1, "R7 flag", proto_err_o, 1);
        chk(lane_en_o == e[12:5] && err_o == e[1], "R7 ignored",
            {lane_en_o, err_o}, {e[12:5], e[1]});
      end
      if (k < int'(w)) begin
        if (inject && k == 1) begin
          start_i = 1'b1; addr_i = ~a; burst_i = 1'b0; size_i = 3'b001; wait_i = 3'd0;
        end
        @(negedge clk_i);
        start_i = 1'b0;
      end
    end
    chk(ack_ok, (w == 0) ? "R1 ack timing" : "R2 ack timing", ack_ok, 1);
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    chk(ack_o == 1'b0, "R3 ack drops", ack_o, 0);
    for (int i = 1; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk({ack_o, lane_en_o, beats_o, err_o, proto_err_o} == '0, "R8 reset",
        {ack_o, lane_en_o, beats_o, err_o, proto_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({ack_o, lane_en_o, beats_o, err_o, proto_err_o} == '0, "R8 after release",
        {ack_o, lane_en_o, beats_o, err_o, proto_err_o}, 0);

    txn(32'h1000_0005, 1'b0, 3'b011, 3'd0, 0); idle(1);  // lanes E0, R1
    txn(32'h1000_0006, 1'b0, 3'b011, 3'd1, 0); idle(1);  // crossing, R6
    txn(32'h1000_0000, 1'b0, 3'b000, 3'd7, 0); idle(1);  // full dword, R2
    txn(32'h1000_0001, 1'b0, 3'b000, 3'd2, 0); idle(1);  // crossing
    txn(32'h1000_0007, 1'b0, 3'b001, 3'd0, 0); idle(1);  // lane 7
    txn(32'h1000_0003, 1'b1, 3'b010, 3'd3, 0); idle(1);  // burst
    txn(32'h1000_0002, 1'b1, 3'b110, 3'd0, 0); idle(1);  // burst ignores size
    txn(32'h1000_0000, 1'b0, 3'b101, 3'd0, 0); idle(1);  // unknown code
    txn(32'h1000_0004, 1'b0, 3'b100, 3'd5, 1); idle(2);  // dropped strobe, R7
    // back-to-back: second strobe in the ack cycle is accepted (R7)
    txn(32'h2000_0002, 1'b0, 3'b010, 3'd1, 0);
    txn(32'h2000_0000, 1'b0, 3'b100, 3'd0, 0);
    txn(32'h2000_0004, 1'b1, 3'b000, 3'd2, 0); idle(1);

    for (int t = 0; t < 300; t++) begin
      logic [2:0] w;
      w = 3'($urandom_range(0, 7));
      txn($urandom, ($urandom_range(0, 3) == 0), 3'($urandom_range(0, 7)), w,
          (w >= 2) && ($urandom_range(0, 4) == 0));
      if ($urandom_range(0, 3) != 0) idle(1 + $urandom_range(0, 2));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule